// File: doc/BRIEF.md
# Pipelined Burst Memory Front End

This block is a single-clock memory with a registered, pipelined read path and a two-bit burst address sequencer. It is built in front of its own storage array. Each word holds 36 bits in four 9-bit lanes. Two active-low address strobes can start an access:

- The processor strobe has priority. An access it starts always opens as a read, and a write can follow on the next edge.
- The controller strobe can write a full word or a subset of lanes on the same edge that captures the address.

Three chip enables qualify each strobe. When a new access is started with any enable inactive, the device is deselected.

Once an access is open, cycles without a strobe continue the burst. Advance low steps a two-bit counter, using either a linear or an interleaved order. Advance high repeats the current address. Every continuation cycle reads, unless its write inputs request a write. Read data appears on a data-out port together with a drive-valid flag, which stands in for a tristate bus. The flag follows an asynchronous active-low output enable, but the data pipeline and the write rules can force it low. A sleep request, synchronised over two edges, freezes the device and keeps the stored contents unchanged.

Top module: `sram_burst_front`

## Requirements
- R1: When both strobes are low on the same edge, the processor strobe is obeyed, so the access is a read and any write inputs on that edge are ignored.
- R2: The processor strobe is ignored while the first chip enable `chipSelAN` is high. An open burst then continues as if no strobe were present.
- R3: A processor-strobe access reads on its start edge whatever the write inputs are. A write on the following edge, with advance high, stores the data presented on that following edge at the same address.
- R4: A controller-strobe write stores the data and lanes presented on the address edge itself. Advance is ignored on that edge.
- R5: Lane i occupies bits [9i+8:9i]. A low `allWriteN` writes all four lanes. Otherwise a low `laneWriteEnN` writes exactly the lanes whose `laneSelN` bit is low, and the other lanes keep their contents.
- R6: Data for an address captured as a read on edge k is on `dataOut`, with `dataOutValid` high, after edge k+1.
- R7: `dataOutValid` is low whenever `outEnN` is high, without waiting for a clock. In the cycle after a read starts from the deselected state it is low even with `outEnN` low.
- R8: The edge of any write cycle drops `dataOutValid`. It stays low through later strobe-less cycles until a read is started by either strobe.
- R9: Chip enables are looked at only on edges with an accepted strobe. A strobe edge with any enable inactive (`chipSelAN` high, `chipSelB` low or `chipSelCN` high) deselects the device, and `dataOutValid` is low right after that edge. After reset the device is deselected and not driving.
- R10: `sleepReq` takes effect on the second edge after it rises and ends on the second edge after it falls. Edges in between ignore all accesses, stored words are kept, and `dataOutValid` is low.
- R11: Burst step n from start low bits s addresses low bits s+n mod 4 when `burstLinear` is 1, and s XOR n when it is 0. The upper address bits stay fixed, advance low moves to the next step, and advance high repeats the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| addrIn | input | ADDR_BITS | Word address, captured with an accepted strobe |
| procStrobeN | input | 1 | Processor address strobe, active low, priority |
| ctrlStrobeN | input | 1 | Controller address strobe, active low |
| advanceN | input | 1 | Burst advance, active low |
| chipSelAN | input | 1 | Chip enable, active low, also gates the processor strobe |
| chipSelB | input | 1 | Chip enable, active high |
| chipSelCN | input | 1 | Chip enable, active low |
| allWriteN | input | 1 | Write all lanes, active low |
| laneWriteEnN | input | 1 | Lane write qualifier, active low |
| laneSelN | input | 4 | Per-lane write select, active low |
| burstLinear | input | 1 | Burst order, 1 linear and 0 interleaved; held static |
| outEnN | input | 1 | Asynchronous output enable, active low |
| sleepReq | input | 1 | Sleep request, active high |
| dataIn | input | 36 | Write data |
| dataOut | output | 36 | Registered read data |
| dataOutValid | output | 1 | High when the block would drive the data bus |

## Verification
The assertions assume that `burstLinear` does not change during a burst. They also assume that `sleepReq` is raised only while the device is deselected, and that reset is held across several edges before it is released, so that pipeline history is known. The stimulus always deselects with a controller strobe before it requests sleep, and it sets the burst order only while the device is idle. All inputs change one nanosecond after a rising edge, so each strobe, enable and write input is stable for a full cycle around the edge that samples it.

// File: rtl/sram_burst_pkg.sv
`timescale 1ns/1ps
package sram_burst_pkg;
  parameter int LANE_COUNT = 4;
  parameter int LANE_BITS = 9;
  localparam int WORD_BITS = LANE_COUNT * LANE_BITS;
  localparam int BURST_BITS = 2;

  // strobes from control to datapath for the current edge
  typedef struct packed {
    logic                  rdFire;
    logic                  busRelease;
    logic [LANE_COUNT-1:0] laneWr;
  } access_strobes_t;
endpackage

// File: rtl/burst_access_ctrl.sv
`timescale 1ns/1ps
module burst_access_ctrl
  import sram_burst_pkg::*;
#(
  parameter int ADDR_BITS = 6
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_BITS-1:0]  addrIn,
  input  logic                  procStrobeN,
  input  logic                  ctrlStrobeN,
  input  logic                  advanceN,
  input  logic                  chipSelAN,
  input  logic                  chipSelB,
  input  logic                  chipSelCN,
  input  logic                  allWriteN,
  input  logic                  laneWriteEnN,
  input  logic [LANE_COUNT-1:0] laneSelN,
  input  logic                  burstLinear,
  input  logic                  sleepReq,
  output access_strobes_t       strobes,
  output logic [ADDR_BITS-1:0]  accessAddr,
  output logic                  sleeping
);
  typedef enum logic [2:0] {ACT_IDLE, ACT_SLEEP, ACT_DESEL, ACT_PROC, ACT_CTRL, ACT_CONT} act_e;

  act_e                  act;
  logic                  selected, writeHold, sleepQ1, sleepQ2;
  logic [ADDR_BITS-1:0]  baseAddr;
  logic [BURST_BITS-1:0] stepCnt, stepNext, lowBits;
  logic                  allSel, procHit, ctrlHit, loadNew;
  logic [LANE_COUNT-1:0] laneReq;

  assign sleeping = sleepQ2;

  always_comb begin
    allSel  = !chipSelAN && chipSelB && !chipSelCN;
    procHit = !procStrobeN && !chipSelAN;
    ctrlHit = !ctrlStrobeN && !procHit;
    loadNew = procHit || ctrlHit;
    if (!allWriteN)         laneReq = '1;
    else if (!laneWriteEnN) laneReq = ~laneSelN;
    else                    laneReq = '0;

    if (sleepQ2)                 act = ACT_SLEEP;
    else if (loadNew && !allSel) act = ACT_DESEL;
    else if (procHit)            act = ACT_PROC;
    else if (ctrlHit)            act = ACT_CTRL;
    else if (selected)           act = ACT_CONT;
    else                         act = ACT_IDLE;

    stepNext = advanceN ? stepCnt : stepCnt + BURST_BITS'(1);
    lowBits  = burstLinear ? baseAddr[BURST_BITS-1:0] + stepNext
                           : baseAddr[BURST_BITS-1:0] ^ stepNext;
    if (act == ACT_PROC || act == ACT_CTRL) accessAddr = addrIn;
    else accessAddr = {baseAddr[ADDR_BITS-1:BURST_BITS], lowBits};

    strobes = '0;
    case (act)
      ACT_PROC: strobes.rdFire = 1'b1;
      ACT_CTRL, ACT_CONT: begin
        if (|laneReq) begin
          strobes.laneWr     = laneReq;
          strobes.busRelease = 1'b1;
        end else begin
          strobes.rdFire = (act == ACT_CTRL) || !writeHold;
        end
      end
      default: strobes.busRelease = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selected  <= 1'b0;
      writeHold <= 1'b0;
      sleepQ1   <= 1'b0;
      sleepQ2   <= 1'b0;
      baseAddr  <= '0;
      stepCnt   <= '0;
    end else begin
      sleepQ1 <= sleepReq;
      sleepQ2 <= sleepQ1;
      case (act)
        ACT_SLEEP, ACT_DESEL: begin
          selected  <= 1'b0;
          writeHold <= 1'b0;
        end
        ACT_PROC, ACT_CTRL: begin
          selected  <= 1'b1;
          baseAddr  <= addrIn;
          stepCnt   <= '0;
          writeHold <= (act == ACT_CTRL) && (|laneReq);
        end
        ACT_CONT: begin
          stepCnt <= stepNext;
          if (|laneReq) writeHold <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  // R1: processor strobe wins over a controller write on the same edge
  assert_proc_wins_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!procStrobeN && !ctrlStrobeN && !chipSelAN && chipSelB && !chipSelCN && !sleeping && !allWriteN)
      |-> (strobes.laneWr == '0 && strobes.rdFire));

  // R4: a controller write lands on the presented address, all lanes under global write
  assert_ctrl_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlStrobeN && procStrobeN && !chipSelAN && chipSelB && !chipSelCN && !sleeping && !allWriteN)
      |-> (strobes.laneWr == '1 && accessAddr == addrIn));

  // R10: nothing reaches the array while asleep
  assert_sleep_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    sleeping |-> (strobes.laneWr == '0 && !strobes.rdFire));
endmodule

// File: rtl/burst_array_path.sv
`timescale 1ns/1ps
module burst_array_path
  import sram_burst_pkg::*;
#(
  parameter int ADDR_BITS = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  access_strobes_t      strobes,
  input  logic [ADDR_BITS-1:0] accessAddr,
  input  logic [WORD_BITS-1:0] dataIn,
  input  logic                 outEnN,
  input  logic                 sleeping,
  output logic [WORD_BITS-1:0] dataOut,
  output logic                 dataOutValid
);
  localparam int DEPTH = 1 << ADDR_BITS;

  logic [WORD_BITS-1:0] rdWord, dataReg;
  logic                 rdStage, busOwn;

  for (genvar g = 0; g < LANE_COUNT; g++) begin : gLane
    logic [LANE_BITS-1:0] laneMem [DEPTH];
    logic [LANE_BITS-1:0] laneRd;
    always_ff @(posedge clk) begin
      if (strobes.laneWr[g]) laneMem[accessAddr] <= dataIn[g*LANE_BITS +: LANE_BITS];
      if (strobes.rdFire)    laneRd <= laneMem[accessAddr];
    end
    assign rdWord[g*LANE_BITS +: LANE_BITS] = laneRd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdStage <= 1'b0;
      busOwn  <= 1'b0;
      dataReg <= '0;
    end else begin
      rdStage <= strobes.rdFire;
      if (rdStage) dataReg <= rdWord;
      busOwn <= rdStage && !strobes.busRelease;
    end
  end

  assign dataOut      = dataReg;
  assign dataOutValid = busOwn && !outEnN && !sleeping;

  // R8: a write edge leaves the bus released
  assert_release_on_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    (|strobes.laneWr) |=> !busOwn);

  // R6: driving only happens two edges after a fired read
  assert_drive_after_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    busOwn |-> $past(strobes.rdFire, 2));
endmodule

// File: rtl/sram_burst_front.sv
`timescale 1ns/1ps
module sram_burst_front
  import sram_burst_pkg::*;
#(
  parameter int ADDR_BITS = 6
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_BITS-1:0]  addrIn,
  input  logic                  procStrobeN,
  input  logic                  ctrlStrobeN,
  input  logic                  advanceN,
  input  logic                  chipSelAN,
  input  logic                  chipSelB,
  input  logic                  chipSelCN,
  input  logic                  allWriteN,
  input  logic                  laneWriteEnN,
  input  logic [LANE_COUNT-1:0] laneSelN,
  input  logic                  burstLinear,
  input  logic                  outEnN,
  input  logic                  sleepReq,
  input  logic [WORD_BITS-1:0]  dataIn,
  output logic [WORD_BITS-1:0]  dataOut,
  output logic                  dataOutValid
);
  access_strobes_t      strobes;
  logic [ADDR_BITS-1:0] accessAddr;
  logic                 sleeping;

  burst_access_ctrl #(.ADDR_BITS(ADDR_BITS)) ctrl_i (
    .clk(clk), .rstN(rstN), .addrIn(addrIn),
    .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN), .advanceN(advanceN),
    .chipSelAN(chipSelAN), .chipSelB(chipSelB), .chipSelCN(chipSelCN),
    .allWriteN(allWriteN), .laneWriteEnN(laneWriteEnN), .laneSelN(laneSelN),
    .burstLinear(burstLinear), .sleepReq(sleepReq),
    .strobes(strobes), .accessAddr(accessAddr), .sleeping(sleeping)
  );

  burst_array_path #(.ADDR_BITS(ADDR_BITS)) path_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .accessAddr(accessAddr),
    .dataIn(dataIn), .outEnN(outEnN), .sleeping(sleeping),
    .dataOut(dataOut), .dataOutValid(dataOutValid)
  );
endmodule

// File: tb/sram_burst_front_tb_top.sv
`timescale 1ns/1ps
module sram_burst_front_tb_top;
  logic clk = 1'b0;
  logic rstN;
  logic [5:0] addrIn;
  logic procStrobeN, ctrlStrobeN, advanceN, chipSelAN, chipSelB, chipSelCN;
  logic allWriteN, laneWriteEnN, burstLinear, outEnN, sleepReq;
  logic [3:0] laneSelN;
  logic [35:0] dataIn, dataOut;
  logic dataOutValid;

  logic [35:0] shadow [64];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // entry: {global, laneSelN, addr, data}
  localparam logic [46:0] VEC [8] = '{
    {1'b1, 4'hF,    6'd3,  36'h1_2345_6789},
    {1'b1, 4'hF,    6'd5,  36'hF_EDCB_A987},
    {1'b0, 4'b1110, 6'd3,  36'hA_AAAA_AAAA},
    {1'b0, 4'b0101, 6'd5,  36'h5_5555_5555},
    {1'b1, 4'hF,    6'd7,  36'h0_0F0F_0F0F},
    {1'b0, 4'b0000, 6'd7,  36'h9_8765_4321},
    {1'b0, 4'b1011, 6'd3,  36'h0_0000_0000},
    {1'b1, 4'h0,    6'd12, 36'hC_3C3C_3C3C}
  };

  always #2.5 clk = ~clk;

  sram_burst_front #(.ADDR_BITS(6)) dut_i (
    .clk(clk), .rstN(rstN), .addrIn(addrIn),
    .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN), .advanceN(advanceN),
    .chipSelAN(chipSelAN), .chipSelB(chipSelB), .chipSelCN(chipSelCN),
    .allWriteN(allWriteN), .laneWriteEnN(laneWriteEnN), .laneSelN(laneSelN),
    .burstLinear(burstLinear), .outEnN(outEnN), .sleepReq(sleepReq),
    .dataIn(dataIn), .dataOut(dataOut), .dataOutValid(dataOutValid)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic expectEq(input string tag, input logic [35:0] got, input logic [35:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic setIdle();
    procStrobeN = 1; ctrlStrobeN = 1; advanceN = 1;
    allWriteN = 1; laneWriteEnN = 1; laneSelN = 4'hF;
    chipSelAN = 0; chipSelB = 1; chipSelCN = 0;
  endtask

  task automatic deselect();
    procStrobeN = 1; ctrlStrobeN = 0; chipSelB = 0;
    allWriteN = 1; laneWriteEnN = 1;
    tick();
    expectEq("R9 released after deselect", 36'(dataOutValid), 36'd0);
    setIdle();
  endtask

  task automatic ctrlWrite(input logic [5:0] a, input logic [35:0] d, input logic [3:0] selN,
                           input bit glob, input bit adv);
    setIdle();
    addrIn = a; dataIn = d; ctrlStrobeN = 0; laneWriteEnN = 0;
    laneSelN = selN; allWriteN = ~glob; advanceN = ~adv;
    tick();
    for (int i = 0; i < 4; i++)
      if (glob || !selN[i]) shadow[a][i*9 +: 9] = d[i*9 +: 9];
    setIdle();
    deselect();
  endtask

  task automatic readCheck(input logic [5:0] a, input string tag);
    setIdle();
    addrIn = a; ctrlStrobeN = 0;
    tick();
    expectEq({tag, " first cycle masked R7"}, 36'(dataOutValid), 36'd0);
    ctrlStrobeN = 1;
    tick();
    expectEq({tag, " valid R6"}, 36'(dataOutValid), 36'd1);
    expectEq({tag, " data R6"}, dataOut, shadow[a]);
    deselect();
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired before the run ended");
    finishRun();
  end

  initial begin
    rstN = 0; setIdle(); sleepReq = 0; outEnN = 0; burstLinear = 1;
    dataIn = '0; addrIn = '0;
    repeat (3) tick();
    rstN = 1;
    tick();
    expectEq("R9 reset not driving", 36'(dataOutValid), 36'd0);

    for (int a = 0; a < 64; a++)
      ctrlWrite(6'(a), 36'(a) * 36'h0_0301_0207 + 36'h5, 4'hF, 1'b1, 1'b0);

    // R5 table: write then read back
    for (int v = 0; v < 8; v++) begin
      ctrlWrite(VEC[v][41:36], VEC[v][35:0], VEC[v][45:42], VEC[v][46], 1'b0);
      readCheck(VEC[v][41:36], "R5 lane table");
    end

    // R4: advance low on a controller write is ignored
    ctrlWrite(6'd30, 36'h7_1234_ABCD, 4'hF, 1'b1, 1'b1);
    readCheck(6'd30, "R4 write address");
    readCheck(6'd31, "R4 neighbour untouched");

    // R3: processor start is a read even with global write low
    setIdle(); addrIn = 6'd20; procStrobeN = 0; allWriteN = 0; dataIn = 36'hD_EAD0_BEEF;
    tick();
    procStrobeN = 1; allWriteN = 1;
    tick();
    expectEq("R3 start reads valid", 36'(dataOutValid), 36'd1);
    expectEq("R3 start reads data", dataOut, shadow[20]);
    deselect();
    readCheck(6'd20, "R3 start left word");
    // R3: write on the following edge
    setIdle(); addrIn = 6'd20; procStrobeN = 0;
    tick();
    procStrobeN = 1; allWriteN = 0; dataIn = 36'h3_3C3C_5A5A;
    tick();
    shadow[20] = 36'h3_3C3C_5A5A;
    expectEq("R8 write releases", 36'(dataOutValid), 36'd0);
    deselect();
    readCheck(6'd20, "R3 late write");

    // R1: both strobes, controller write loses
    setIdle(); addrIn = 6'd21; procStrobeN = 0; ctrlStrobeN = 0; allWriteN = 0;
    dataIn = 36'hB_AD00_0BAD;
    tick();
    setIdle();
    tick();
    expectEq("R1 read data", dataOut, shadow[21]);
    deselect();
    readCheck(6'd21, "R1 no write");

    // R2, R9, R7, R8 on one open burst at 21
    setIdle(); addrIn = 6'd21; ctrlStrobeN = 0;
    tick();
    ctrlStrobeN = 1;
    tick();
    procStrobeN = 0; chipSelAN = 1; chipSelB = 0;
    tick();
    expectEq("R2 R9 burst continues valid", 36'(dataOutValid), 36'd1);
    expectEq("R2 R9 burst continues data", dataOut, shadow[21]);
    setIdle();
    outEnN = 1; #1;
    expectEq("R7 output enable high", 36'(dataOutValid), 36'd0);
    outEnN = 0; #1;
    expectEq("R7 output enable low", 36'(dataOutValid), 36'd1);
    laneWriteEnN = 0; laneSelN = 4'b1110; dataIn = 36'h0_0000_01FF;
    tick();
    shadow[21][8:0] = 9'h1FF;
    expectEq("R8 write edge releases", 36'(dataOutValid), 36'd0);
    setIdle();
    tick();
    tick();
    expectEq("R8 stays released", 36'(dataOutValid), 36'd0);
    addrIn = 6'd21; ctrlStrobeN = 0;
    tick();
    ctrlStrobeN = 1;
    tick();
    expectEq("R8 strobe read drives", 36'(dataOutValid), 36'd1);
    expectEq("R5 lane0 merged", dataOut, shadow[21]);
    deselect();

    // R11 linear: base 9 -> 9,10,11,8 then hold
    for (int m = 1; m >= 0; m--) begin
      logic [5:0] seq [4];
      burstLinear = m[0];
      for (int n = 0; n < 4; n++)
        seq[n] = m[0] ? 6'(8 + ((1 + n) % 4)) : 6'(8 + (1 ^ n));
      setIdle(); addrIn = 6'd9; ctrlStrobeN = 0;
      tick();
      ctrlStrobeN = 1; advanceN = 0;
      for (int n = 0; n < 3; n++) begin
        tick();
        expectEq("R11 burst step", dataOut, shadow[seq[n]]);
      end
      advanceN = 1;
      tick();
      expectEq("R11 burst last step", dataOut, shadow[seq[3]]);
      tick();
      expectEq("R11 advance high holds", dataOut, shadow[seq[3]]);
      deselect();
    end
    burstLinear = 1;

    // R10 sleep
    sleepReq = 1;
    tick(); tick();
    addrIn = 6'd30; ctrlStrobeN = 0; allWriteN = 0; dataIn = 36'hE_EEEE_EEEE;
    tick();
    expectEq("R10 asleep not driving", 36'(dataOutValid), 36'd0);
    setIdle(); sleepReq = 0;
    tick(); tick();
    readCheck(6'd30, "R10 contents kept");

    finishRun();
  end
endmodule